// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block moves 18-bit words from one clock domain to another through a dual-port store. It works in fall-through fashion: a word that lands in an empty FIFO is loaded into the read-side output register without any read request, so the consumer sees valid data on `rd_data` as soon as `or_n` drops. Because that output register holds a word of its own, the usable capacity is `DEPTH + 1`. Every fill threshold is counted against that total.

Both sides use a valid/ready handshake with active-low pins. On the write side, `wr_en_n` is the valid and `ir_n` is the ready. A word transfers on a rising `wclk` edge where both are low. While `ir_n` is high the producer is back-pressured and its request has no effect. On the read side, `or_n` is the valid and `rd_en_n` is the ready. A word is consumed on a rising `rclk` edge where both are low. The next stored word, if one is visible, replaces it on that same edge.

Pointers cross between the domains in Gray code through two-flop synchronisers. The ready and almost-full/half-full flags are produced in the write domain. The output-ready and almost-empty flags are produced in the read domain. The two offsets are static inputs. `DEPTH` must be a power of two, at least 4. `pae_off` must be below `DEPTH - 1` and `paf_off` below `DEPTH`.

Top module: `fwft_fifo`

## Requirements
- R1: While `rst` is high and after it falls, with no traffic, the flags are `or_n`=1, `ir_n`=0, `pae_n`=0, `paf_n`=1 and `hf_n`=1.
- R2: After a write into an empty FIFO, `or_n` stays high through two rising `rclk` edges and falls on the third. With a skew-window violation this can be one edge later. `rd_data` then shows that word without any read. It holds the word, with `or_n` low, until a read takes it. `or_n` is 0 exactly when at least one word is held.
- R3: The FIFO accepts exactly `DEPTH + 1` words without reads. `ir_n` is 1 exactly when that many are held.
- R4: A write is taken on a rising `wclk` edge with `wr_en_n`=0 and `ir_n`=0. A read is taken on a rising `rclk` edge with `rd_en_n`=0 and `or_n`=0. Words leave in the order they were taken.
- R5: Once the flags have settled, `paf_n` is 0 exactly when the held count is at least `DEPTH + 1 - paf_off`.
- R6: Once the flags have settled, `hf_n` is 0 exactly when the held count is at least `DEPTH/2 + 2`.
- R7: Once the flags have settled, `pae_n` is 1 exactly when the held count is at least `pae_off + 2`.
- R8: A write attempted while `ir_n` is 1 stores nothing. A read attempted while `or_n` is 1 removes nothing and does not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Asynchronous reset, active high, both domains |
| wr_en_n | input | 1 | Write request (valid), active low |
| wr_data | input | DATA_W | Write data |
| ir_n | output | 1 | Input ready, active low |
| rd_en_n | input | 1 | Read request (ready), active low |
| rd_data | output | DATA_W | Output register contents |
| or_n | output | 1 | Output ready (valid), active low |
| pae_off | input | AW+1 | Almost-empty offset |
| paf_off | input | AW+1 | Almost-full offset |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
Several properties are checked on every edge by the assertions. The write-side fill never passes the store depth. A blocked write never advances the write pointer. A full FIFO always reports almost-full and half-full. A presented word stays put until it is read. `or_n` only returns high after a read. The cycle count to first-word visibility, the exact `DEPTH + 1` capacity, every flag threshold as the count climbs and falls, and data ordering under overlapping traffic on unrelated clocks can only be shown by the bench's scenarios.

// File: rtl/fwft_pkg.sv
`timescale 1ns/1ps
package fwft_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic        FLAG_ON     = 1'b0;
  localparam logic        FLAG_OFF    = 1'b1;
endpackage

// File: rtl/fwft_sync.sv
`timescale 1ns/1ps
// Gray-coded pointer synchroniser; decodes to binary after the last stage.
module fwft_sync #(
  parameter int W      = 5,
  parameter int STAGES = fwft_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage [STAGES];

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= gray_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign bin_out = gray_to_bin(stage[STAGES-1]);
endmodule

// File: rtl/fwft_mem.sv
`timescale 1ns/1ps
// Dual-port store: written in the write domain, read asynchronously by address.
module fwft_mem #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fwft_wr_ctrl.sv
`timescale 1ns/1ps
// Write-domain pointer and full-side flags. Fill counts stored words only;
// the output register supplies the extra word of the total.
module fwft_wr_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic [PW-1:0] rd_bin_s,
  input  logic [PW-1:0] paf_off,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wr_gray,
  output logic [PW-1:0] wr_bin,
  output logic [PW-1:0] fill,
  output logic          ir_n,
  output logic          paf_n,
  output logic          hf_n
);
  import fwft_pkg::*;

  localparam logic [PW:0] FULL_MARK = (PW+1)'(DEPTH);
  localparam logic [PW:0] HALF_MARK = (PW+1)'(DEPTH / 2 + 1);

  logic [PW-1:0] bin_q, bin_nx, fill_nx;
  logic [PW:0]   fill_ext, paf_sum;

  assign we       = !wr_en_n && (ir_n == FLAG_ON);
  assign bin_nx   = bin_q + PW'(we);
  assign fill_nx  = bin_nx - rd_bin_s;
  assign fill_ext = {1'b0, fill_nx};
  assign paf_sum  = fill_ext + {1'b0, paf_off};

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      bin_q   <= '0;
      wr_gray <= '0;
      ir_n    <= FLAG_ON;
      paf_n   <= FLAG_OFF;
      hf_n    <= FLAG_OFF;
    end else begin
      bin_q   <= bin_nx;
      wr_gray <= bin_nx ^ (bin_nx >> 1);
      ir_n    <= (fill_ext >= FULL_MARK) ? FLAG_OFF : FLAG_ON;
      paf_n   <= (paf_sum  >= FULL_MARK) ? FLAG_ON  : FLAG_OFF;
      hf_n    <= (fill_ext >= HALF_MARK) ? FLAG_ON  : FLAG_OFF;
    end
  end

  assign waddr  = bin_q[AW-1:0];
  assign wr_bin = bin_q;
  assign fill   = bin_q - rd_bin_s;
endmodule

// File: rtl/fwft_rd_ctrl.sv
`timescale 1ns/1ps
// Read-domain pointer, output register and empty-side flags.
module fwft_rd_ctrl #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int PW     = AW + 1
) (
  input  logic              rclk,
  input  logic              rst,
  input  logic              rd_en_n,
  input  logic [PW-1:0]     wr_bin_s,
  input  logic [PW-1:0]     pae_off,
  input  logic [DATA_W-1:0] mem_q,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rd_gray,
  output logic [DATA_W-1:0] rd_data,
  output logic              or_n,
  output logic              pae_n
);
  import fwft_pkg::*;

  logic [PW-1:0] bin_q, bin_nx, stored_nx;
  logic          held, held_nx, take, fetch;
  logic [PW:0]   total_nx, pae_mark;

  assign take      = !rd_en_n && held;
  assign fetch     = (wr_bin_s != bin_q) && (!held || take);
  assign held_nx   = fetch || (held && !take);
  assign bin_nx    = bin_q + PW'(fetch);
  assign stored_nx = wr_bin_s - bin_nx;
  assign total_nx  = {1'b0, stored_nx} + (PW+1)'(held_nx);
  assign pae_mark  = {1'b0, pae_off} + (PW+1)'(2);

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      bin_q   <= '0;
      rd_gray <= '0;
      held    <= 1'b0;
      rd_data <= '0;
      pae_n   <= FLAG_ON;
    end else begin
      bin_q   <= bin_nx;
      rd_gray <= bin_nx ^ (bin_nx >> 1);
      held    <= held_nx;
      if (fetch) rd_data <= mem_q;
      pae_n   <= (total_nx >= pae_mark) ? FLAG_OFF : FLAG_ON;
    end
  end

  assign raddr = bin_q[AW-1:0];
  assign or_n  = held ? FLAG_ON : FLAG_OFF;
endmodule

// File: rtl/fwft_fifo.sv
`timescale 1ns/1ps
module fwft_fifo #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 512
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst,
  input  logic                     wr_en_n,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     ir_n,
  input  logic                     rd_en_n,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     or_n,
  input  logic [$clog2(DEPTH):0]   pae_off,
  input  logic [$clog2(DEPTH):0]   paf_off,
  output logic                     pae_n,
  output logic                     paf_n,
  output logic                     hf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] w_gray, r_gray, w_bin, w_fill, w_bin_s, r_bin_s;
  logic [DATA_W-1:0] mem_q;

  fwft_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .rst(rst), .wr_en_n(wr_en_n), .rd_bin_s(r_bin_s),
    .paf_off(paf_off), .we(we), .waddr(waddr), .wr_gray(w_gray),
    .wr_bin(w_bin), .fill(w_fill), .ir_n(ir_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  fwft_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  fwft_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst(rst), .gray_in(w_gray), .bin_out(w_bin_s)
  );

  fwft_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst(rst), .gray_in(r_gray), .bin_out(r_bin_s)
  );

  fwft_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rst(rst), .rd_en_n(rd_en_n), .wr_bin_s(w_bin_s),
    .pae_off(pae_off), .mem_q(mem_q), .raddr(raddr), .rd_gray(r_gray),
    .rd_data(rd_data), .or_n(or_n), .pae_n(pae_n)
  );
endmodule

// File: rtl/fwft_fifo_chk.sv
`timescale 1ns/1ps
module fwft_fifo_chk #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 512,
  parameter int PW     = $clog2(DEPTH) + 1
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              ir_n,
  input logic              or_n,
  input logic              paf_n,
  input logic              hf_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [PW-1:0]     w_bin,
  input logic [PW-1:0]     w_fill
);
  AST_FILL_BOUND: assert property (@(posedge wclk) disable iff (rst)
    {1'b0, w_fill} <= (PW+1)'(DEPTH)); // R3
  AST_BLOCKED_WRITE: assert property (@(posedge wclk) disable iff (rst)
    (ir_n && !wr_en_n) |=> $stable(w_bin)); // R8
  AST_FULL_PAF: assert property (@(posedge wclk) disable iff (rst)
    ir_n |-> !paf_n); // R5
  AST_FULL_HF: assert property (@(posedge wclk) disable iff (rst)
    ir_n |-> !hf_n); // R6
  AST_OUT_HOLD: assert property (@(posedge rclk) disable iff (rst)
    (!or_n && rd_en_n) |=> (!or_n && $stable(rd_data))); // R2
  AST_EMPTY_AFTER_READ: assert property (@(posedge rclk) disable iff (rst)
    $rose(or_n) |-> $past(!rd_en_n)); // R4
endmodule

bind fwft_fifo fwft_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_fwft_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .ir_n(ir_n), .or_n(or_n), .paf_n(paf_n), .hf_n(hf_n), .rd_data(rd_data),
  .w_bin(w_bin), .w_fill(w_fill)
);

// File: tb/fwft_fifo_bench.sv
`timescale 1ns/100ps
module fwft_fifo_bench;
  localparam int DW = 18;
  localparam int DEP = 16;
  localparam int D = DEP + 1;
  localparam int N = 3;
  localparam int M = 2;

  logic wclk = 0, rclk = 0, rst = 1;
  logic wr_en_n = 1, rd_en_n = 1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic ir_n, or_n, pae_n, paf_n, hf_n;
  logic [4:0] pae_off = 5'(N), paf_off = 5'(M);

  int checks = 0, failures = 0, reads = 0;
  logic [DW-1:0] exp_q [$];

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  fwft_fifo #(.DATA_W(DW), .DEPTH(DEP)) u_fwft_fifo (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .ir_n(ir_n), .rd_en_n(rd_en_n), .rd_data(rd_data), .or_n(or_n),
    .pae_off(pae_off), .paf_off(paf_off), .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_flags(input int cnt);
    chk("R3 ir_n", ir_n, int'(cnt >= D));
    chk("R5 paf_n", paf_n, int'(!(cnt >= D - M)));
    chk("R6 hf_n", hf_n, int'(!(cnt >= (D - 1) / 2 + 2)));
    chk("R7 pae_n", pae_n, int'(cnt >= N + 2));
    chk("R2 or_n", or_n, int'(cnt == 0));
  endtask

  task automatic settle();
    repeat (10) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #1;
  endtask

  // called just after a wclk edge; leaves wr_en_n low
  task automatic wr_try(input logic [DW-1:0] d, output bit took);
    wr_en_n = 0;
    wr_data = d;
    @(negedge wclk);
    took = !ir_n;
    if (took) exp_q.push_back(d);
    @(posedge wclk);
    #1;
  endtask

  task automatic rd_one();
    @(posedge rclk); #1 rd_en_n = 0;
    @(posedge rclk); #1 rd_en_n = 1;
  endtask

  // scoreboard monitor (R4)
  always @(negedge rclk) begin
    if (!rst && !rd_en_n && !or_n) begin
      if (exp_q.size() == 0) chk("R4 read with empty scoreboard", 1, 0);
      else chk("R4 data order", int'(rd_data), int'(exp_q.pop_front()));
      reads++;
    end
  end

  initial begin
    repeat (150000) @(posedge wclk);
    failures++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit took;
    int cnt, base;
    #20;
    chk("R1 or_n in reset", or_n, 1);
    chk("R1 ir_n in reset", ir_n, 0);
    #11 rst = 0;
    settle();
    chk("R1 or_n", or_n, 1);
    chk("R1 ir_n", ir_n, 0);
    chk("R1 pae_n", pae_n, 0);
    chk("R1 paf_n", paf_n, 1);
    chk("R1 hf_n", hf_n, 1);

    // R2: fall-through latency
    @(posedge wclk); #1;
    wr_en_n = 0; wr_data = 18'h2A5A5;
    exp_q.push_back(18'h2A5A5);
    @(posedge wclk);
    wr_en_n <= 1'b1;
    repeat (2) @(posedge rclk);
    #0.5 chk("R2 or_n high after two rclk edges", or_n, 1);
    @(posedge rclk);
    #0.5 chk("R2 or_n low at third rclk edge", or_n, 0);
    chk("R2 word shown without read", int'(rd_data), 18'h2A5A5);
    settle();
    cnt = 1;
    check_flags(cnt);

    // R3/R5/R6/R7: fill one word at a time
    for (int k = 2; k <= D; k++) begin
      wr_try(DW'(18'h100 + k), took);
      wr_en_n = 1;
      chk("R3 write accepted below capacity", int'(took), 1);
      settle();
      cnt = k;
      check_flags(cnt);
    end

    // R8: write while full is ignored
    @(posedge wclk); #1;
    wr_try(18'h1FFFF, took);
    wr_try(18'h1FFFE, took);
    wr_en_n = 1;
    chk("R8 write while full", int'(took), 0);
    settle();
    check_flags(cnt);

    // drain one at a time, flags tracked on the way down
    for (int k = D - 1; k >= 0; k--) begin
      rd_one();
      settle();
      cnt = k;
      check_flags(cnt);
    end
    chk("R3 all words returned", exp_q.size(), 0);

    // R8: reads while empty are ignored
    base = reads;
    @(posedge rclk); #1 rd_en_n = 0;
    repeat (10) @(posedge rclk);
    #1 rd_en_n = 1;
    chk("R8 no read while empty", reads - base, 0);
    chk("R8 or_n stays high", or_n, 1);
    @(posedge wclk); #1;
    wr_try(18'h3C3C3, took);
    wr_en_n = 1;
    settle();
    chk("R8 new word visible", or_n, 0);
    chk("R8 read position unmoved", int'(rd_data), 18'h3C3C3);
    rd_one();
    settle();
    chk("R2 or_n after last read", or_n, 1);

    // R4: overlapping traffic
    base = reads;
    fork
      begin
        @(posedge wclk); #1;
        for (int i = 0; i < 150; i++) begin
          if (i % 4 == 3) begin
            wr_en_n = 1;
            @(posedge wclk); #1;
          end
          took = 0;
          while (!took) wr_try(DW'(i * 37 + 5), took);
        end
        wr_en_n = 1;
      end
      begin
        int j = 0;
        while (reads - base < 150) begin
          @(posedge rclk); #1 rd_en_n = (j % 5 == 1);
          j++;
        end
        rd_en_n = 1;
      end
    join
    settle();
    chk("R4 stream count", reads - base, 150);
    chk("R4 scoreboard empty", exp_q.size(), 0);
    chk("R2 empty after stream", or_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule